// File: doc/BRIEF.md
# Line-Locked Clock Divider and Reset Sequencer

This block is the digital back end of a line-locked video clock generator. An analog loop outside the block multiplies a line-frequency reference by four and delivers that fast clock here. The block hands the fast clock on as a pair of full-rate outputs. It divides the fast clock by two to make a pair of half-rate outputs, and it makes a half-rate qualifier that marks which full-rate edges carry a half-rate rising edge. Every clock output is parked HIGH whenever the system is not running, so downstream logic sees no edge until the loop is locked and the timed reset is over.

The system reset output is the end result of a small sequencer. A low power-good input clears everything at once. Chip enable LOW parks the block. When chip enable is HIGH, the sequencer waits for the selected lock indication to stay HIGH for `LOCK_CYC` consecutive fast-clock edges. It then counts `DELAY_CYC` more edges and releases the reset. Losing lock or changing the reference source starts the wait again. The control pins are plain levels sampled on the fast clock. There is no streaming interface, so no valid/ready handshake or back-pressure applies.

Top module: `llclk_gen`

## Requirements
- R1: While running, both full-rate outputs equal the fast clock. While not running they are HIGH. The two copies are always equal.
- R2: While running, both half-rate outputs toggle on every rising fast-clock edge, which gives half the fast-clock frequency at 50% duty. The two copies are always equal.
- R3: While not running, the half-rate outputs and the qualifier are HIGH.
- R4: `chip_en` sampled LOW at a rising edge parks the sequencer at that edge. `sys_rst_n` is then 0 and all clocks are HIGH until a new sequence completes.
- R5: `pwr_good` LOW resets the block at once, without waiting for a clock edge. After it returns HIGH, a complete new sequence is needed.
- R6: Leaving the parked state with `chip_en` HIGH takes one edge to enter the wait. The selected lock must then be sampled HIGH on `LOCK_CYC` consecutive edges, and a further `DELAY_CYC` edges must pass. Only after that does `sys_rst_n` go to 1, and from that edge on the block is running.
- R7: While waiting, delaying or running, a LOW selected lock or a change of `ref_sel` returns the sequencer to the start of the lock wait. `sys_rst_n` goes to 0 at that edge.
- R8: At the release edge the half-rate outputs go LOW. Their first rising edge coincides with the first rising edge of the full-rate outputs.
- R9: While running, the qualifier is the complement of the half-rate output. It is HIGH in exactly the fast-clock periods that end in a half-rate rising edge.
- R10: `ref_sel`=0 selects `lock_pri` and `ref_sel`=1 selects `lock_sec`. The lock input that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock from the loop, four times the reference |
| pwr_good | input | 1 | Supply-good level; LOW acts as an asynchronous reset |
| chip_en | input | 1 | Chip enable; LOW parks the block |
| ref_sel | input | 1 | Reference source select: 0 primary, 1 secondary |
| lock_pri | input | 1 | Lock indication with the primary reference |
| lock_sec | input | 1 | Lock indication with the secondary reference |
| clk_full_a | output | 1 | Full-rate clock, copy A |
| clk_full_b | output | 1 | Full-rate clock, copy B |
| clk_half_a | output | 1 | Half-rate clock, copy A |
| clk_half_b | output | 1 | Half-rate clock, copy B |
| clk_qual | output | 1 | Half-rate qualifier |
| sys_rst_n | output | 1 | System reset, active LOW |

## Verification
On every cycle the assertions check four things. A LOW chip enable parks the sequencer. A lost lock while running forces the wait. Release happens only from the delay state with lock present. While running, the half-rate and qualifier registers toggle in complement, and outside running they are parked HIGH. Only the bench scenarios can show the exact cycle count from enable to release and the async effect of a supply dip. They also show that the lock input which is not selected has no effect, and that the first half-rate edge lines up with the first full-rate edge. To do this the bench compares a behavioural model against every output in both clock phases.

// File: rtl/llclk_pkg.sv
package llclk_pkg;
  typedef enum logic [1:0] {
    SEQ_PARK  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_DELAY = 2'd2,
    SEQ_RUN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/llclk_seq.sv
module llclk_seq
  import llclk_pkg::*;
#(
  parameter int LOCK_CYC  = 16,
  parameter int DELAY_CYC = 64
) (
  input  logic clk_fast,
  input  logic pwr_good,
  input  logic chip_en,
  input  logic ref_sel,
  input  logic lock_pri,
  input  logic lock_sec,
  output logic run,
  output logic run_nxt
);
  localparam int MAXC = (LOCK_CYC > DELAY_CYC) ? LOCK_CYC : DELAY_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOCK_LAST  = CW'(LOCK_CYC - 1);
  localparam logic [CW-1:0] DELAY_LAST = CW'(DELAY_CYC - 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_q;
  logic          lock_sel, sel_moved;

  assign lock_sel  = ref_sel ? lock_sec : lock_pri;
  assign sel_moved = ref_sel != sel_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!chip_en) begin
      state_d = SEQ_PARK;
      cnt_d   = '0;
    end else if (state_q == SEQ_PARK) begin
      state_d = SEQ_WAIT;
      cnt_d   = '0;
    end else if (!lock_sel || sel_moved) begin
      state_d = SEQ_WAIT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_WAIT: begin
          if (cnt_q == LOCK_LAST) begin
            state_d = SEQ_DELAY;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SEQ_DELAY: begin
          if (cnt_q == DELAY_LAST) begin
            state_d = SEQ_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = SEQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_fast or negedge pwr_good) begin
    if (!pwr_good) begin
      state_q <= SEQ_PARK;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sel_q   <= ref_sel;
    end
  end

  assign run     = state_q == SEQ_RUN;
  assign run_nxt = state_d == SEQ_RUN;

  assert_disable_parks_R4: assert property (@(posedge clk_fast) disable iff (!pwr_good)
    !chip_en |=> (state_q == SEQ_PARK));

  assert_lockloss_waits_R7: assert property (@(posedge clk_fast) disable iff (!pwr_good)
    (chip_en && state_q == SEQ_RUN && !lock_sel) |=> (state_q == SEQ_WAIT));

  assert_release_after_delay_R6: assert property (@(posedge clk_fast) disable iff (!pwr_good)
    (state_q != SEQ_RUN) ##1 (state_q == SEQ_RUN) |-> ($past(state_q) == SEQ_DELAY) && $past(lock_sel));
endmodule

// File: rtl/llclk_div.sv
module llclk_div (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic run,
  input  logic run_nxt,
  output logic half_q,
  output logic qual_q
);
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b1;
      qual_q <= 1'b1;
    end else if (!run_nxt) begin
      half_q <= 1'b1;
      qual_q <= 1'b1;
    end else if (!run) begin
      half_q <= 1'b0;
      qual_q <= 1'b1;
    end else begin
      half_q <= ~half_q;
      qual_q <= ~qual_q;
    end
  end

  assert_half_toggles_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (run && run_nxt) |=> (half_q != $past(half_q)));

  assert_parked_high_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !run |-> (half_q && qual_q));

  assert_qual_phase_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    run |-> (qual_q != half_q));

  assert_start_low_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!run && run_nxt) |=> !half_q);
endmodule

// File: rtl/llclk_gen.sv
module llclk_gen #(
  parameter int LOCK_CYC  = 16,
  parameter int DELAY_CYC = 64
) (
  input  logic clk_fast,
  input  logic pwr_good,
  input  logic chip_en,
  input  logic ref_sel,
  input  logic lock_pri,
  input  logic lock_sec,
  output logic clk_full_a,
  output logic clk_full_b,
  output logic clk_half_a,
  output logic clk_half_b,
  output logic clk_qual,
  output logic sys_rst_n
);
  logic run, run_nxt, half_q, qual_q, full_gated;

  llclk_seq #(
    .LOCK_CYC (LOCK_CYC),
    .DELAY_CYC(DELAY_CYC)
  ) u_seq (
    .clk_fast(clk_fast),
    .pwr_good(pwr_good),
    .chip_en (chip_en),
    .ref_sel (ref_sel),
    .lock_pri(lock_pri),
    .lock_sec(lock_sec),
    .run     (run),
    .run_nxt (run_nxt)
  );

  llclk_div u_div (
    .clk_fast(clk_fast),
    .rst_n   (pwr_good),
    .run     (run),
    .run_nxt (run_nxt),
    .half_q  (half_q),
    .qual_q  (qual_q)
  );

  // run changes only just after a rising edge, while the clock is high,
  // so the OR gate cannot produce a short pulse.
  assign full_gated = clk_fast | ~run;

  assign clk_full_a = full_gated;
  assign clk_full_b = full_gated;
  assign clk_half_a = half_q;
  assign clk_half_b = half_q;
  assign clk_qual   = qual_q;
  assign sys_rst_n  = run;

  assert_copies_match_R1: assert property (@(negedge clk_fast) disable iff (!pwr_good)
    (clk_full_a == clk_full_b) && (clk_half_a == clk_half_b));
endmodule

// File: tb/test_llclk_gen.sv
`timescale 1ns/100ps
module test_llclk_gen;
  localparam int LCYC = 4;
  localparam int DCYC = 10;

  logic clk_fast = 1'b0;
  logic pwr_good = 1'b0;
  logic chip_en  = 1'b0;
  logic ref_sel  = 1'b0;
  logic lock_pri = 1'b0;
  logic lock_sec = 1'b0;
  logic clk_full_a, clk_full_b, clk_half_a, clk_half_b, clk_qual, sys_rst_n;

  int checks = 0;
  int errors = 0;

  always #2 clk_fast = ~clk_fast;

  llclk_gen #(.LOCK_CYC(LCYC), .DELAY_CYC(DCYC)) i_llclk_gen (
    .clk_fast  (clk_fast),
    .pwr_good  (pwr_good),
    .chip_en   (chip_en),
    .ref_sel   (ref_sel),
    .lock_pri  (lock_pri),
    .lock_sec  (lock_sec),
    .clk_full_a(clk_full_a),
    .clk_full_b(clk_full_b),
    .clk_half_a(clk_half_a),
    .clk_half_b(clk_half_b),
    .clk_qual  (clk_qual),
    .sys_rst_n (sys_rst_n)
  );

  // Behavioural model: phase 0 parked, 1 lock wait, 2 delay, 3 running.
  int   m_phase = 0;
  int   m_count = 0;
  logic m_sel   = 1'b0;
  logic m_half  = 1'b1;
  logic m_qual  = 1'b1;

  always @(posedge clk_fast or negedge pwr_good) begin
    if (!pwr_good) begin
      m_phase = 0; m_count = 0; m_sel = 1'b0; m_half = 1'b1; m_qual = 1'b1;
    end else begin
      int  nph, ncnt;
      bit  lk, was_run, now_run;
      lk   = ref_sel ? lock_sec : lock_pri;
      nph  = m_phase;
      ncnt = m_count;
      if (!chip_en) begin nph = 0; ncnt = 0; end
      else if (m_phase == 0) begin nph = 1; ncnt = 0; end
      else if (!lk || ref_sel != m_sel) begin nph = 1; ncnt = 0; end
      else if (m_phase == 1) begin
        if (m_count == LCYC - 1) begin nph = 2; ncnt = 0; end else ncnt = m_count + 1;
      end else if (m_phase == 2) begin
        if (m_count == DCYC - 1) begin nph = 3; ncnt = 0; end else ncnt = m_count + 1;
      end
      was_run = (m_phase == 3);
      now_run = (nph == 3);
      if (!now_run) begin m_half = 1'b1; m_qual = 1'b1; end
      else if (!was_run) begin m_half = 1'b0; m_qual = 1'b1; end
      else begin m_half = ~m_half; m_qual = ~m_qual; end
      m_phase = nph;
      m_count = ncnt;
      m_sel   = ref_sel;
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", what, $time, act, exp);
    end
  endtask

  // High phase: full-rate outputs are always HIGH (R1).
  always @(posedge clk_fast) begin
    #0.5;
    chk(clk_full_a, 1'b1, "R1 full_a high phase");
    chk(clk_full_b, 1'b1, "R1 full_b high phase");
  end

  // Low phase: compare every output against the model.
  always @(negedge clk_fast) begin
    #0.5;
    if (m_phase == 3) begin
      chk(clk_full_a, 1'b0, "R1 full_a low phase");
      chk(clk_full_b, 1'b0, "R1 full_b low phase");
      chk(clk_half_a, m_half, "R2 half_a");
      chk(clk_half_b, m_half, "R2 half_b");
      chk(clk_qual, m_qual, "R9 qualifier");
    end else begin
      chk(clk_full_a, 1'b1, "R3 full_a parked");
      chk(clk_full_b, 1'b1, "R3 full_b parked");
      chk(clk_half_a, 1'b1, "R3 half_a parked");
      chk(clk_half_b, 1'b1, "R3 half_b parked");
      chk(clk_qual, 1'b1, "R3 qualifier parked");
    end
    chk(sys_rst_n, (m_phase == 3), "R6 reset output");
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_fast);
    #1;
  endtask

  task automatic wait_release(input string tag);
    int k = 0;
    while (sys_rst_n !== 1'b1 && k < 200) begin cycles(1); k++; end
    chk(sys_rst_n, 1'b1, tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int start_edge;
    cycles(3);
    chk(sys_rst_n, 1'b0, "R5 reset state");
    pwr_good = 1'b1;
    cycles(5);
    chk(sys_rst_n, 1'b0, "R4 parked while chip_en low");
    lock_pri = 1'b1;
    chip_en  = 1'b1;
    // R6: 1 edge to wait, LCYC lock edges, DCYC delay edges.
    cycles(LCYC + DCYC);
    chk(sys_rst_n, 1'b0, "R6 one edge before release");
    cycles(1);
    chk(sys_rst_n, 1'b1, "R6 released on schedule");
    chk(clk_half_a, 1'b0, "R8 half low after release");
    chk(clk_qual, 1'b1, "R8 qualifier high before first edge");
    cycles(1);
    chk(clk_half_a, 1'b1, "R8 half rose with first full edge");
    cycles(20);
    // R10: unselected lock has no effect.
    lock_sec = 1'b0;
    cycles(6);
    chk(sys_rst_n, 1'b1, "R10 lock_sec ignored while ref_sel=0");
    // R7: brief lock loss restarts.
    lock_pri = 1'b0;
    cycles(1);
    chk(sys_rst_n, 1'b0, "R7 lock loss drops reset");
    lock_pri = 1'b1;
    cycles(2);
    lock_pri = 1'b0;
    cycles(1);
    lock_pri = 1'b1;
    wait_release("R7 recovered after lock flicker");
    cycles(9);
    // R7/R10: source change with secondary locked.
    lock_sec = 1'b1;
    ref_sel  = 1'b1;
    cycles(1);
    chk(sys_rst_n, 1'b0, "R7 source change drops reset");
    wait_release("R10 run on secondary lock");
    lock_pri = 1'b0;
    cycles(8);
    chk(sys_rst_n, 1'b1, "R10 lock_pri ignored while ref_sel=1");
    // R4: chip enable low parks.
    chip_en = 1'b0;
    cycles(1);
    chk(sys_rst_n, 1'b0, "R4 chip_en low drops reset");
    cycles(5);
    chip_en = 1'b1;
    start_edge = 0;
    wait_release("R4 re-enable restarts sequence");
    cycles(7);
    // R5: supply dip acts at once.
    pwr_good = 1'b0;
    #0.5;
    chk(sys_rst_n, 1'b0, "R5 async reset on supply dip");
    chk(clk_half_a, 1'b1, "R5 half parked on supply dip");
    cycles(3);
    pwr_good = 1'b1;
    cycles(LCYC + DCYC);
    chk(sys_rst_n, 1'b0, "R5 full sequence needed after dip");
    wait_release("R5 release after dip");
    cycles(12);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule